// File: doc/BRIEF.md
# UART byte-counted RAM loader

This block sits between a byte-level serial receiver and a RAM write port. It fills RAM from a fixed load base with the bytes that arrive. The serial line carries idle-high NRZ frames, each with one start bit, eight data bits and one stop bit. The bit-level receiver is a separate block and hands over each byte with a one-cycle valid strobe. The first byte of a load is a length. That length counts every byte of the load, the length byte included, and the length byte is itself stored at the load base.

Once the counted number of bytes has been taken in, the block marks the load complete. It then raises a one-cycle start request to the processor, with an entry address one above the load base. If the length promises more bytes than the sender delivers, the block waits for them forever and never issues a start request. A reset at that point restarts the loader and leaves the RAM as it is. Bytes that would land above the top of RAM are dropped and raise a sticky overflow flag.

Top module: `uart_ram_loader`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `ram_we`, `exec_req`, `load_done` and `overflow` are all 0.
- R2: Each accepted byte appears on the write port in the cycle after its `rx_valid` cycle, as exactly one `ram_we` pulse carrying that byte. The first byte goes to LOAD_BASE (0x50 by default) and each later byte goes to the next higher address. This holds whether the bytes are spaced apart or arrive on back-to-back cycles.
- R3: For a length value N of at least 2, the load ends after N bytes in total, the length byte included. `load_done` rises in the cycle the final write is presented and stays high until reset. `exec_req` is high for exactly one cycle, in the cycle after that.
- R4: `exec_addr` always equals LOAD_BASE+1 (0x51 by default).
- R5: A length value of 0 or 1 stores only the length byte at LOAD_BASE and completes the load at once, with the R3 timing.
- R6: If fewer than N bytes arrive, `load_done` stays 0 and no `exec_req` is issued, however long the line stays quiet.
- R7: A reset issues no RAM writes, so RAM that is already loaded is left untouched. After a reset the next byte is again taken as a length and stored at LOAD_BASE.
- R8: Once `load_done` is high, further bytes cause no write and no second `exec_req`.
- R9: No write is ever issued above RAM_TOP (0xFF by default). A byte whose address would exceed RAM_TOP is discarded but still counts toward N. `overflow` rises in the cycle after the first such byte and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| load_done | output | 1 | The counted load is complete |
| exec_req | output | 1 | One-cycle request to start execution |
| exec_addr | output | ADDR_W | Entry address, LOAD_BASE+1 |
| overflow | output | 1 | A byte was dropped at the top of RAM |

## Verification
The properties assume that `rx_valid` and `rx_data` are driven cleanly around each clock edge. They also assume that a byte offered during reset may be lost. The stimulus changes inputs only on falling edges and holds `rx_valid` high for exactly one cycle per byte, or across consecutive cycles for a burst. It offers no bytes while reset is high.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LS_COUNT = 2'd0,
        LS_DATA  = 2'd1,
        LS_DONE  = 2'd2
    } ldr_state_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] data;
    } wr_beat_t;

    // A length of 0 or 1 covers only the length byte itself.
    function automatic logic cnt_trivial(input logic [BYTE_W-1:0] c);
        return c <= BYTE_W'(1);
    endfunction

endpackage

// File: rtl/ldr_seq.sv
module ldr_seq
    import ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              take,
    output logic              done,
    output logic              exec_req
);
    ldr_state_e        state;
    logic [BYTE_W-1:0] remain;
    logic              fin;
    logic              fin_q;

    always_comb begin
        take = rx_valid && (state != LS_DONE);
        fin  = take && (((state == LS_COUNT) && cnt_trivial(rx_data)) ||
                        ((state == LS_DATA) && (remain == BYTE_W'(1))));
        done = (state == LS_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_COUNT;
            remain   <= '0;
            fin_q    <= 1'b0;
            exec_req <= 1'b0;
        end else begin
            fin_q    <= fin;
            exec_req <= fin_q;
            if (take) begin
                unique case (state)
                    LS_COUNT: begin
                        if (cnt_trivial(rx_data)) begin
                            state <= LS_DONE;
                        end else begin
                            remain <= rx_data - BYTE_W'(1);
                            state  <= LS_DATA;
                        end
                    end
                    LS_DATA: begin
                        remain <= remain - BYTE_W'(1);
                        if (fin) state <= LS_DONE;
                    end
                    default: state <= state;
                endcase
            end
        end
    end
endmodule

// File: rtl/ldr_addr_gen.sv
module ldr_addr_gen #(
    parameter int ADDR_W    = 8,
    parameter int LOAD_BASE = 'h50,
    parameter int RAM_TOP   = 'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    output logic              in_range,
    output logic [ADDR_W-1:0] addr,
    output logic              overflow
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] BASE_P = PTR_W'(LOAD_BASE);
    localparam logic [PTR_W-1:0] TOP_P  = PTR_W'(RAM_TOP);

    logic [PTR_W-1:0] wptr;

    always_comb begin
        in_range = (wptr <= TOP_P);
        addr     = wptr[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= BASE_P;
            overflow <= 1'b0;
        end else if (take) begin
            if (in_range) wptr     <= wptr + PTR_W'(1);
            else          overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/ldr_wport.sv
module ldr_wport
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);
    wr_beat_t          beat_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            addr_q <= '0;
        end else begin
            beat_q.we <= wr_en;
            if (wr_en) begin
                beat_q.data <= wr_data;
                addr_q      <= wr_addr;
            end
        end
    end

    always_comb begin
        ram_we    = beat_q.we;
        ram_addr  = addr_q;
        ram_wdata = beat_q.data;
    end
endmodule

// File: rtl/uart_ram_loader.sv
module uart_ram_loader
    import ldr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LOAD_BASE = 'h50,
    parameter int RAM_TOP   = 'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              load_done,
    output logic              exec_req,
    output logic [ADDR_W-1:0] exec_addr,
    output logic              overflow
);
    localparam logic [ADDR_W-1:0] ENTRY = ADDR_W'(LOAD_BASE + 1);

    logic              take;
    logic              in_range;
    logic [ADDR_W-1:0] next_addr;

    assign exec_addr = ENTRY;

    ldr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .take     (take),
        .done     (load_done),
        .exec_req (exec_req)
    );

    ldr_addr_gen #(
        .ADDR_W    (ADDR_W),
        .LOAD_BASE (LOAD_BASE),
        .RAM_TOP   (RAM_TOP)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .in_range (in_range),
        .addr     (next_addr),
        .overflow (overflow)
    );

    ldr_wport #(
        .ADDR_W (ADDR_W)
    ) u_wport (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (take && in_range),
        .wr_addr   (next_addr),
        .wr_data   (rx_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );
endmodule

// File: rtl/uart_ram_loader_chk.sv
module uart_ram_loader_chk #(
    parameter int ADDR_W    = 8,
    parameter int LOAD_BASE = 'h50,
    parameter int RAM_TOP   = 'hFF
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_wdata,
    input logic              load_done,
    input logic              exec_req,
    input logic              overflow
);
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(LOAD_BASE);
    localparam logic [ADDR_W:0] TOP_X  = (ADDR_W+1)'(RAM_TOP);

    a_r2_write_from_byte: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ($past(rx_valid) && (ram_wdata == $past(rx_data))));

    a_r3_exec_one_cycle: assert property (@(posedge clk) disable iff (rst)
        exec_req |=> !exec_req);

    a_r3_exec_after_done: assert property (@(posedge clk) disable iff (rst)
        exec_req |-> load_done);

    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        ($past(load_done) && load_done) |-> !ram_we);

    a_r9_addr_in_ram: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (({1'b0, ram_addr} >= BASE_X) && ({1'b0, ram_addr} <= TOP_X)));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind uart_ram_loader uart_ram_loader_chk #(
    .ADDR_W    (ADDR_W),
    .LOAD_BASE (LOAD_BASE),
    .RAM_TOP   (RAM_TOP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .load_done (load_done),
    .exec_req  (exec_req),
    .overflow  (overflow)
);

// File: tb/uart_ram_loader_tb.sv
`timescale 1ns/1ps
module uart_ram_loader_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       load_done;
    logic       exec_req;
    logic [7:0] exec_addr;
    logic       overflow;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int exec_cnt = 0;
    int cycles = 0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    uart_ram_loader u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .load_done(load_done), .exec_req(exec_req), .exec_addr(exec_addr),
        .overflow(overflow)
    );

    // Model RAM fed from the write port
    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) if (exec_req) exec_cnt <= exec_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Drive at a falling edge, then check the write port one cycle later.
    task automatic send_byte(input logic [7:0] b, input bit exp_we,
                             input logic [7:0] exp_addr, input string req);
        if (!clk) begin end
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(ram_we == exp_we, {req, " we"}, ram_we, exp_we);
        if (exp_we) begin
            chk(ram_addr == exp_addr, {req, " addr"}, ram_addr, exp_addr);
            chk(ram_wdata == b, {req, " data"}, ram_wdata, b);
        end
    endtask

    task automatic check_finish(input string req);
        chk(load_done == 1'b1, {req, " done"}, load_done, 1);
        chk(exec_req == 1'b0, {req, " exec early"}, exec_req, 0);
        @(negedge clk);
        chk(exec_req == 1'b1, {req, " exec"}, exec_req, 1);
        chk(exec_addr == 8'h51, "R4 entry", exec_addr, 8'h51);
        @(negedge clk);
        chk(exec_req == 1'b0, {req, " exec pulse"}, exec_req, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(ram_we == 0 && exec_req == 0 && load_done == 0 && overflow == 0,
            "R1 reset outputs", {ram_we, exec_req, load_done, overflow}, 0);
    endtask

    task automatic t_normal();
        logic [7:0] d [5] = '{8'h05, 8'hA1, 8'hB2, 8'hC3, 8'hD4};
        int e0;
        do_reset();
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            send_byte(d[i], 1'b1, 8'h50 + 8'(i), "R2 spaced");
            if (i < 4) begin
                chk(load_done == 0, "R3 not done", load_done, 0);
                @(negedge clk);
            end
        end
        check_finish("R3");
        for (int i = 0; i < 5; i++)
            chk(mem[8'h50 + 8'(i)] == d[i], "R2 ram", mem[8'h50 + 8'(i)], d[i]);
        e0 = exec_cnt;
        send_byte(8'h77, 1'b0, 8'h00, "R8 extra");
        idle(4);
        chk(exec_cnt == e0, "R8 no second exec", exec_cnt, e0);
        chk(load_done == 1, "R8 done held", load_done, 1);
    endtask

    task automatic t_trivial(input logic [7:0] c);
        do_reset();
        @(negedge clk);
        send_byte(c, 1'b1, 8'h50, "R5 short length");
        check_finish("R5");
        chk(mem[8'h50] == c, "R5 ram", mem[8'h50], c);
    endtask

    task automatic t_burst();
        do_reset();
        @(negedge clk);
        send_byte(8'h04, 1'b1, 8'h50, "R2 burst");
        send_byte(8'h11, 1'b1, 8'h51, "R2 burst");
        send_byte(8'h22, 1'b1, 8'h52, "R2 burst");
        send_byte(8'h33, 1'b1, 8'h53, "R2 burst");
        check_finish("R3 burst");
    endtask

    task automatic t_stall_and_reset();
        int w0;
        int e0;
        do_reset();
        e0 = exec_cnt;
        @(negedge clk);
        send_byte(8'h06, 1'b1, 8'h50, "R6 len");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            send_byte(8'hE0 + 8'(i), 1'b1, 8'h51 + 8'(i), "R6 data");
        end
        idle(60);
        chk(load_done == 0, "R6 stalled done", load_done, 0);
        chk(exec_cnt == e0, "R6 no exec", exec_cnt, e0);
        w0 = wr_cnt;
        do_reset();
        chk(ram_we == 0 && load_done == 0, "R1 after stall reset",
            {ram_we, load_done}, 0);
        idle(5);
        chk(wr_cnt == w0, "R7 no writes on reset", wr_cnt, w0);
        chk(mem[8'h50] == 8'h06 && mem[8'h53] == 8'hE2, "R7 ram kept",
            mem[8'h53], 8'hE2);
        send_byte(8'h02, 1'b1, 8'h50, "R7 restart at base");
        @(negedge clk);
        send_byte(8'h99, 1'b1, 8'h51, "R7 restart data");
        check_finish("R7");
    endtask

    task automatic t_overflow();
        int w0;
        do_reset();
        w0 = wr_cnt;
        @(negedge clk);
        send_byte(8'd200, 1'b1, 8'h50, "R9 len");
        for (int i = 1; i < 200; i++) begin
            @(negedge clk);
            send_byte(8'(i), (i < 176), 8'h50 + 8'(i), "R9 data");
            if (i == 175) chk(overflow == 0, "R9 no early flag", overflow, 0);
            if (i == 176) chk(overflow == 1, "R9 flag", overflow, 1);
            if (i < 199) chk(load_done == 0, "R9 not done", load_done, 0);
        end
        check_finish("R9");
        chk(wr_cnt - w0 == 176, "R9 write count", wr_cnt - w0, 176);
        chk(mem[8'hFF] == 8'd175, "R9 top byte", mem[8'hFF], 175);
        chk(overflow == 1, "R9 flag held", overflow, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset_state();
        t_normal();
        t_trivial(8'h01);
        t_trivial(8'h00);
        t_burst();
        t_stall_and_reset();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule